// File: doc/BRIEF.md
# Legacy Prefix and Opcode Escape Decoder

This block sits at the front of an instruction decode path. It accepts one instruction byte per cycle through a valid/ready handshake. It sorts the leading legacy prefix bytes into four groups: lock/repeat, segment override, operand-size override and address-size override. These prefixes may come in any order. It then follows the opcode escape bytes to find which opcode map the instruction uses and which byte is the final opcode.

When an instruction ends, the block holds a result record. It stays until the consumer accepts it through a second valid/ready handshake, and the input side is stalled meanwhile. The record holds:

- one field per prefix group;
- a resolved mandatory-prefix candidate for the SIMD opcode maps;
- the opcode map and the opcode byte;
- branch-hint flags, which are raised only for conditional jumps;
- a flag for a repeated prefix group;
- a flag for an over-length byte sequence.

Top module: `pfx_escape_decoder`

## Requirements
- R1: After synchronous reset, `out_valid` is 0, `in_ready` is 1, and every result field reads 0.
- R2: The prefix groups are recognised in any order. Group 1 is reported on `rep_grp`: F0 reads 1, F2 reads 2, F3 reads 3. Group 2 is reported on `seg_ovr`: 26 reads 1, 2E reads 2, 36 reads 3, 3E reads 4, 64 reads 5, 65 reads 6. Byte 66 sets `opsize_ovr` and byte 67 sets `addrsize_ovr`.
- R3: A second prefix from a group that is already filled replaces the earlier value and sets `dup_group`.
- R4: `mand_pfx` reports the F2 or F3 byte that arrived last, whichever it was, even if a later F0 overwrote `rep_grp` (F2 reads 2, F3 reads 3). If neither byte arrived, `mand_pfx` reads 1 when 66 was seen, and 0 otherwise.
- R5: The pair 0F 38 gives map 2 and the pair 0F 3A gives map 3, with the following byte as the opcode. A 0F followed by any other byte gives map 1 with that byte as the opcode.
- R6: A first non-prefix byte other than 0F ends the instruction with map 0, and that byte is the opcode.
- R7: `hint_taken` (segment code 4) and `hint_not_taken` (segment code 2) are raised only when the opcode is a conditional jump. That means map 0 with an opcode of 70 to 7F, or map 1 with an opcode of 80 to 8F.
- R8: The length limit is 15 bytes. If byte 15 is accepted and it does not complete an opcode, the result is emitted with `len_err` set to 1 and `opcode` set to 00. If an opcode completes on byte 15, `len_err` stays 0.
- R9: While `out_valid` is high and `out_ready` is low, `in_ready` is 0. In that state no input byte is taken and the result stays unchanged.
- R10: A result handshake (`out_valid` and `out_ready` both high) clears all group and result state for the next instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction byte offered |
| in_byte | input | 8 | Instruction byte |
| in_ready | output | 1 | Byte can be accepted |
| out_valid | output | 1 | Decoded result available |
| out_ready | input | 1 | Consumer takes the result |
| rep_grp | output | 2 | Lock/repeat group code |
| seg_ovr | output | 3 | Segment override code |
| opsize_ovr | output | 1 | Operand-size override seen |
| addrsize_ovr | output | 1 | Address-size override seen |
| mand_pfx | output | 2 | Mandatory-prefix candidate |
| opc_map | output | 2 | Opcode map |
| opcode | output | 8 | Final opcode byte |
| hint_taken | output | 1 | Branch-taken hint on a conditional jump |
| hint_not_taken | output | 1 | Branch-not-taken hint on a conditional jump |
| dup_group | output | 1 | A prefix group was filled twice |
| len_err | output | 1 | Length limit reached without an opcode |

## Verification
The length limit and opcode completion can land on the same byte. The bench provokes this three ways:

- fourteen 66 bytes followed by a one-byte opcode;
- fifteen 66 bytes;
- thirteen prefixes followed by 0F 38, so that byte 15 is an escape and not an opcode.

In the first case the completion must win, so `len_err` must be 0 and the opcode must be reported. In the other two the length error must win and the opcode must read 00. The duplicate-group flag is checked in the same results, because a run of repeated 66 bytes also fills group 3 more than once.

// File: rtl/pfx_pkg.sv
package pfx_pkg;

  typedef enum logic [1:0] {G1_NONE = 2'd0, G1_LOCK = 2'd1, G1_REPNE = 2'd2, G1_REP = 2'd3} g1_e;
  typedef enum logic [2:0] {SEG_NONE = 3'd0, SEG_ES = 3'd1, SEG_CS = 3'd2, SEG_SS = 3'd3,
                            SEG_DS = 3'd4, SEG_FS = 3'd5, SEG_GS = 3'd6} seg_e;
  typedef enum logic [1:0] {MP_NONE = 2'd0, MP_OPSZ = 2'd1, MP_REPNE = 2'd2, MP_REP = 2'd3} mand_e;
  typedef enum logic [1:0] {MAP_ONE = 2'd0, MAP_0F = 2'd1, MAP_0F38 = 2'd2, MAP_0F3A = 2'd3} map_e;

  // grp: 0 lock/repeat, 1 segment, 2 operand size, 3 address size
  typedef struct packed {
    logic       is_pfx;
    logic [1:0] grp;
    logic [2:0] code;
  } pfx_info_t;

  localparam logic [7:0] ESC_BYTE = 8'h0F;
  localparam logic [7:0] ESC_38   = 8'h38;
  localparam logic [7:0] ESC_3A   = 8'h3A;

  function automatic pfx_info_t classify(input logic [7:0] b);
    pfx_info_t r;
    r = '0;
    r.is_pfx = 1'b1;
    unique case (b)
      8'hF0: begin r.grp = 2'd0; r.code = 3'(G1_LOCK);  end
      8'hF2: begin r.grp = 2'd0; r.code = 3'(G1_REPNE); end
      8'hF3: begin r.grp = 2'd0; r.code = 3'(G1_REP);   end
      8'h26: begin r.grp = 2'd1; r.code = SEG_ES; end
      8'h2E: begin r.grp = 2'd1; r.code = SEG_CS; end
      8'h36: begin r.grp = 2'd1; r.code = SEG_SS; end
      8'h3E: begin r.grp = 2'd1; r.code = SEG_DS; end
      8'h64: begin r.grp = 2'd1; r.code = SEG_FS; end
      8'h65: begin r.grp = 2'd1; r.code = SEG_GS; end
      8'h66: begin r.grp = 2'd2; r.code = 3'd1; end
      8'h67: begin r.grp = 2'd3; r.code = 3'd1; end
      default: r.is_pfx = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/pfx_group_regs.sv
module pfx_group_regs
  import pfx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       load,
  input  logic [7:0] byte_in,
  output logic [1:0] g1,
  output logic [2:0] seg,
  output logic       opsz,
  output logic       adsz,
  output logic [1:0] mand,
  output logic       dup
);

  pfx_info_t info;
  logic [1:0] last_rep;

  assign info = classify(byte_in);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      g1       <= '0;
      seg      <= '0;
      opsz     <= 1'b0;
      adsz     <= 1'b0;
      last_rep <= '0;
      dup      <= 1'b0;
    end else if (load && info.is_pfx) begin
      case (info.grp)
        2'd0: begin
          if (g1 != 2'd0) dup <= 1'b1;
          g1 <= info.code[1:0];
          if (info.code[1:0] == 2'(G1_REPNE) || info.code[1:0] == 2'(G1_REP))
            last_rep <= info.code[1:0];
        end
        2'd1: begin
          if (seg != 3'd0) dup <= 1'b1;
          seg <= info.code;
        end
        2'd2: begin
          if (opsz) dup <= 1'b1;
          opsz <= 1'b1;
        end
        default: begin
          if (adsz) dup <= 1'b1;
          adsz <= 1'b1;
        end
      endcase
    end
  end

  always_comb begin
    if (last_rep == 2'(G1_REPNE))    mand = MP_REPNE;
    else if (last_rep == 2'(G1_REP)) mand = MP_REP;
    else if (opsz)                   mand = MP_OPSZ;
    else                             mand = MP_NONE;
  end

  // R10
  clr_empties_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (g1 == 2'd0 && seg == 3'd0 && !opsz && !adsz && !dup && mand == MP_NONE));

  // R3
  dup_source_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(dup) |-> $past(load));

endmodule

// File: rtl/pfx_escape_fsm.sv
module pfx_escape_fsm
  import pfx_pkg::*;
#(
  parameter int MAX_LEN = 15
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  input  logic [7:0] in_byte,
  input  logic       out_ready,
  output logic       in_ready,
  output logic       out_valid,
  output logic       pfx_load,
  output logic       clr,
  output logic [1:0] map,
  output logic [7:0] opcode,
  output logic       len_err,
  output logic       jcc
);

  localparam int CW = $clog2(MAX_LEN + 1);

  typedef enum logic [1:0] {ST_PFX, ST_ESC1, ST_ESC2, ST_DONE} st_e;

  st_e       state;
  logic [CW-1:0] cnt;
  pfx_info_t info;
  logic      accept;
  logic      last_slot;

  assign info      = classify(in_byte);
  assign in_ready  = (state != ST_DONE);
  assign out_valid = (state == ST_DONE);
  assign accept    = in_valid && in_ready;
  assign pfx_load  = accept && (state == ST_PFX);
  assign clr       = out_valid && out_ready;
  assign last_slot = (cnt == CW'(MAX_LEN - 1));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      state   <= ST_PFX;
      cnt     <= '0;
      map     <= MAP_ONE;
      opcode  <= '0;
      len_err <= 1'b0;
      jcc     <= 1'b0;
    end else if (accept) begin
      cnt <= cnt + CW'(1);
      case (state)
        ST_PFX: begin
          if (info.is_pfx || in_byte == ESC_BYTE) begin
            if (in_byte == ESC_BYTE) map <= MAP_0F;
            if (last_slot) begin
              state   <= ST_DONE;
              len_err <= 1'b1;
            end else if (in_byte == ESC_BYTE) begin
              state <= ST_ESC1;
            end
          end else begin
            opcode <= in_byte;
            map    <= MAP_ONE;
            jcc    <= (in_byte[7:4] == 4'h7);
            state  <= ST_DONE;
          end
        end
        ST_ESC1: begin
          if (in_byte == ESC_38 || in_byte == ESC_3A) begin
            map <= (in_byte == ESC_38) ? MAP_0F38 : MAP_0F3A;
            if (last_slot) begin
              state   <= ST_DONE;
              len_err <= 1'b1;
            end else begin
              state <= ST_ESC2;
            end
          end else begin
            opcode <= in_byte;
            jcc    <= (in_byte[7:4] == 4'h8);
            state  <= ST_DONE;
          end
        end
        ST_ESC2: begin
          opcode <= in_byte;
          state  <= ST_DONE;
        end
        default: ;
      endcase
    end
  end

  // R8
  len_err_opcode_chk: assert property (@(posedge clk) disable iff (rst)
    len_err |-> (out_valid && opcode == 8'h00));

  // R9
  hold_result_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(opcode) && $stable(map) && $stable(len_err)));

  // R6
  one_byte_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && state == ST_PFX && !info.is_pfx && in_byte != ESC_BYTE)
      |=> (out_valid && map == MAP_ONE && opcode == $past(in_byte)));

endmodule

// File: rtl/pfx_escape_decoder.sv
module pfx_escape_decoder
  import pfx_pkg::*;
#(
  parameter int MAX_LEN = 15
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  input  logic [7:0] in_byte,
  output logic       in_ready,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [1:0] rep_grp,
  output logic [2:0] seg_ovr,
  output logic       opsize_ovr,
  output logic       addrsize_ovr,
  output logic [1:0] mand_pfx,
  output logic [1:0] opc_map,
  output logic [7:0] opcode,
  output logic       hint_taken,
  output logic       hint_not_taken,
  output logic       dup_group,
  output logic       len_err
);

  logic pfx_load;
  logic clr;
  logic jcc;

  pfx_escape_fsm #(.MAX_LEN(MAX_LEN)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_byte   (in_byte),
    .out_ready (out_ready),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .pfx_load  (pfx_load),
    .clr       (clr),
    .map       (opc_map),
    .opcode    (opcode),
    .len_err   (len_err),
    .jcc       (jcc)
  );

  pfx_group_regs u_groups (
    .clk     (clk),
    .rst     (rst),
    .clr     (clr),
    .load    (pfx_load),
    .byte_in (in_byte),
    .g1      (rep_grp),
    .seg     (seg_ovr),
    .opsz    (opsize_ovr),
    .adsz    (addrsize_ovr),
    .mand    (mand_pfx),
    .dup     (dup_group)
  );

  assign hint_taken     = out_valid && jcc && (seg_ovr == SEG_DS);
  assign hint_not_taken = out_valid && jcc && (seg_ovr == SEG_CS);

  // R7
  hint_jcc_chk: assert property (@(posedge clk) disable iff (rst)
    (hint_taken || hint_not_taken) |-> (out_valid && !len_err &&
      ((opc_map == MAP_ONE && opcode[7:4] == 4'h7) || (opc_map == MAP_0F && opcode[7:4] == 4'h8))));

  // R4
  mand_opsz_chk: assert property (@(posedge clk) disable iff (rst)
    (mand_pfx == MP_OPSZ) |-> opsize_ovr);

  // R9
  stall_input_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready && in_valid) |=> $stable(rep_grp) && $stable(seg_ovr) && $stable(opsize_ovr));

endmodule

// File: tb/pfx_escape_decoder_tb.sv
module pfx_escape_decoder_tb;

  logic       clk = 1'b0;
  logic       rst;
  logic       in_valid;
  logic [7:0] in_byte;
  logic       in_ready;
  logic       out_valid;
  logic       out_ready;
  logic [1:0] rep_grp;
  logic [2:0] seg_ovr;
  logic       opsize_ovr;
  logic       addrsize_ovr;
  logic [1:0] mand_pfx;
  logic [1:0] opc_map;
  logic [7:0] opcode;
  logic       hint_taken;
  logic       hint_not_taken;
  logic       dup_group;
  logic       len_err;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  pfx_escape_decoder u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready), .rep_grp(rep_grp), .seg_ovr(seg_ovr),
    .opsize_ovr(opsize_ovr), .addrsize_ovr(addrsize_ovr), .mand_pfx(mand_pfx),
    .opc_map(opc_map), .opcode(opcode), .hint_taken(hint_taken),
    .hint_not_taken(hint_not_taken), .dup_group(dup_group), .len_err(len_err)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // bytes packed first-byte-most-significant, n bytes used
  task automatic feed(input logic [8*15-1:0] bytes, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_byte  = bytes[8*(n-1-i) +: 8];
    end
    @(negedge clk);
    in_valid = 1'b0;
    while (!out_valid) @(negedge clk);
  endtask

  task automatic take();
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic chk_res(input string req, input int g1, input int sg, input int os, input int as,
                         input int mp, input int mapv, input int op, input int dp, input int le);
    chk({req, " out_valid"}, int'(out_valid), 1);
    chk({req, " rep_grp"}, int'(rep_grp), g1);
    chk({req, " seg_ovr"}, int'(seg_ovr), sg);
    chk({req, " opsize_ovr"}, int'(opsize_ovr), os);
    chk({req, " addrsize_ovr"}, int'(addrsize_ovr), as);
    chk({req, " mand_pfx"}, int'(mand_pfx), mp);
    if (le == 0) chk({req, " opc_map"}, int'(opc_map), mapv);
    chk({req, " opcode"}, int'(opcode), op);
    chk({req, " dup_group"}, int'(dup_group), dp);
    chk({req, " len_err"}, int'(len_err), le);
  endtask

  task automatic t_reset();
    chk("R1 out_valid", int'(out_valid), 0);
    chk("R1 in_ready", int'(in_ready), 1);
    chk("R1 fields", int'({rep_grp, seg_ovr, opsize_ovr, addrsize_ovr, mand_pfx, opc_map, opcode,
                          hint_taken, hint_not_taken, dup_group, len_err}), 0);
  endtask

  task automatic t_three_byte_map();
    feed({8'h66, 8'hF2, 8'h0F, 8'h38, 8'h29}, 5);
    chk_res("R5 R4 0F38", 2, 0, 1, 0, 2, 2, 8'h29, 0, 0);
    take();
    feed({8'h66, 8'h0F, 8'h3A, 8'h0F}, 4);
    chk_res("R5 R4 0F3A", 0, 0, 1, 0, 1, 3, 8'h0F, 0, 0);
    take();
  endtask

  task automatic t_one_byte_after_clear();
    feed({8'h90}, 1);
    chk_res("R6 R10 plain", 0, 0, 0, 0, 0, 0, 8'h90, 0, 0);
    take();
  endtask

  task automatic t_any_order();
    feed({8'h2E, 8'h67, 8'hF0, 8'h89}, 4);
    chk_res("R2 order a", 1, 2, 0, 1, 0, 0, 8'h89, 0, 0);
    chk("R7 no hint on non-jump", int'({hint_taken, hint_not_taken}), 0);
    take();
    feed({8'h67, 8'h66, 8'h65, 8'hF3, 8'h8B}, 5);
    chk_res("R2 order b", 3, 6, 1, 1, 3, 0, 8'h8B, 0, 0);
    take();
  endtask

  task automatic t_duplicate();
    feed({8'h26, 8'h64, 8'h8B}, 3);
    chk_res("R3 dup seg", 0, 5, 0, 0, 0, 0, 8'h8B, 1, 0);
    take();
  endtask

  task automatic t_mandatory();
    feed({8'hF3, 8'hF2, 8'hF0, 8'h0F, 8'h10}, 5);
    chk_res("R4 last rep", 1, 0, 0, 0, 2, 1, 8'h10, 1, 0);
    take();
    feed({8'hF2, 8'h66, 8'hF3, 8'h0F, 8'h58}, 5);
    chk_res("R4 rep over opsz", 3, 0, 1, 0, 3, 1, 8'h58, 1, 0);
    take();
    feed({8'h0F, 8'h05}, 2);
    chk_res("R5 two byte", 0, 0, 0, 0, 0, 1, 8'h05, 0, 0);
    take();
  endtask

  task automatic t_hints();
    feed({8'h3E, 8'h74}, 2);
    chk("R7 taken short jcc", int'(hint_taken), 1);
    chk("R7 taken short jcc nt", int'(hint_not_taken), 0);
    take();
    feed({8'h2E, 8'h0F, 8'h85}, 3);
    chk("R7 not taken near jcc", int'(hint_not_taken), 1);
    chk("R7 not taken near jcc t", int'(hint_taken), 0);
    take();
    feed({8'h3E, 8'h0F, 8'h74}, 3);
    chk("R7 0F 74 is no jcc", int'({hint_taken, hint_not_taken}), 0);
    take();
  endtask

  task automatic t_length();
    feed({{14{8'h66}}, 8'h90}, 15);
    chk_res("R8 opcode on byte 15", 0, 0, 1, 0, 1, 0, 8'h90, 1, 0);
    take();
    feed({15{8'h66}}, 15);
    chk_res("R8 fifteen prefixes", 0, 0, 1, 0, 1, 0, 8'h00, 1, 1);
    take();
    feed({{13{8'h66}}, 8'h0F, 8'h38}, 15);
    chk_res("R8 escape on byte 15", 0, 0, 1, 0, 1, 0, 8'h00, 1, 1);
    take();
  endtask

  task automatic t_backpressure();
    feed({8'hC3}, 1);
    for (int i = 0; i < 3; i++) begin
      in_valid = 1'b1;
      in_byte  = 8'h66;
      @(negedge clk);
      chk("R9 in_ready low", int'(in_ready), 0);
      chk("R9 opsize untouched", int'(opsize_ovr), 0);
      chk("R9 opcode held", int'(opcode), 8'hC3);
    end
    in_valid = 1'b0;
    take();
    feed({8'h90}, 1);
    chk_res("R9 R10 next after stall", 0, 0, 0, 0, 0, 0, 8'h90, 0, 0);
    take();
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog (R1-R10 run): actual hung expected finished");
    finish_run();
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_byte = 8'h00; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_three_byte_map();
    t_one_byte_after_clear();
    t_any_order();
    t_duplicate();
    t_mandatory();
    t_hints();
    t_length();
    t_backpressure();
    finish_run();
  end

endmodule